// File: doc/BRIEF.md
# Flash toggle-bit completion poller

This block runs on the host side of a parallel flash device and decides when an embedded program or erase operation inside the device has finished. After the command has gone out elsewhere, a start pulse hands the poller three things: a status address, the byte that was meant to be written, and a mode bit. The poller then reads that one location over and over through a simple request/valid read port. It watches bit 6 of each returned byte, which flips on every read while the operation is busy. It also watches bit 5, which signals an internal error or timeout.

Completion is detected when two back-to-back reads agree in bit 6. When bit 6 is still moving but bit 5 is set, the two bits may have changed together. So the poller takes two further reads and judges on their bit 6 alone. In program mode, a successful finish is followed by one read-back of the address, compared in full against the intended byte. Erase mode skips that read. A poll-count limit ends a run that never settles. The result appears as a one-cycle done pulse, with pass, fail and mismatch flags that stay put until the next start.

Top module: `flash_done_poller`

## Requirements
- R1: While rst_ni is low and after reset release, rd_req_o, done_o, pass_o, fail_o and mismatch_o are 0.
- R2: Each read is a single-cycle rd_req_o with rd_addr_o equal to the address latched at start. The byte on rd_data_i is taken in the first cycle from the request cycle onward in which rd_valid_i is high. No new request is issued before that.
- R3: The first read of a run only records bit 6. Every later poll read whose bit 6 equals bit 6 of the read before it ends polling as a pass.
- R4: A poll read whose bit 6 differs from the previous read and whose bit 5 is 0 leads to another poll read.
- R5: A poll read whose bit 6 differs and whose bit 5 is 1 leads to exactly two more reads. Equal bit 6 in those two gives pass; unequal gives fail. pass_o and fail_o are never both 1.
- R6: With mode_prog_i = 1 at start, a pass is followed by one more read of the same address. mismatch_o is 1 when all 8 bits of that byte do not equal data_i latched at start.
- R7: With mode_prog_i = 0 at start, no read-back is made and mismatch_o stays 0.
- R8: If MAX_POLLS poll reads (reads after the first) all toggle with bit 5 = 0, the run ends with fail after exactly 1 + MAX_POLLS reads.
- R9: done_o is high for exactly one cycle per run, together with the final flags. pass_o, fail_o and mismatch_o are cleared when a start is accepted and otherwise change only with done_o.
- R10: start_i is ignored while a run is in progress. The run's reads, address and outcome are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_prog_i | input | 1 | 1 = program (verify read), 0 = erase |
| addr_i | input | AW | Status / target address |
| data_i | input | 8 | Intended byte for the verify compare |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation finished without error |
| fail_o | output | 1 | Error confirmed or poll limit reached |
| mismatch_o | output | 1 | Read-back differs from intended byte |

## Verification
Assertions check on every cycle the shape of the read handshake. They confirm one-cycle requests, no second request while a read is outstanding, and a bounded number of reads per run. They also check the done pulse width, the exclusivity of pass and fail, the rule that mismatch only accompanies pass, and the rule that flags move only at start or done. Only the bench scenarios can show that the right outcome and the right number of reads follow from a given sequence of status bytes. These scenarios sweep settle points, error onsets, response latencies, both modes and never-settling devices, and compare against an arithmetic model of the polling rules.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int unsigned TOG_BIT = 6;
  localparam int unsigned ERR_BIT = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_POLL,
    ST_RCHK_A,
    ST_RCHK_B,
    ST_VERIFY
  } fdp_state_e;
endpackage

// File: rtl/fdp_read_port.sv
module fdp_read_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  output logic       rd_req_o,
  input  logic       rd_valid_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] data_o,
  output logic       vld_o
);
  logic       req_q, wait_q, vld_q;
  logic [7:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      req_q <= issue_i;
      vld_q <= 1'b0;
      if (issue_i) begin
        wait_q <= 1'b1;
      end else if (wait_q && rd_valid_i) begin
        wait_q <= 1'b0;
        vld_q  <= 1'b1;
        dat_q  <= rd_data_i;
      end
    end
  end

  assign rd_req_o = req_q;
  assign data_o   = dat_q;
  assign vld_o    = vld_q;
endmodule

// File: rtl/fdp_poll_watchdog.sv
module fdp_poll_watchdog #(
  parameter int unsigned MAX_POLLS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // high while the poll being judged is the last one allowed
  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/fdp_toggle_track.sv
module fdp_toggle_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  output logic same_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b0;
    else if (load_i) last_q <= bit_i;
  end

  assign same_o = (bit_i == last_q);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int unsigned AW        = 18,
  parameter int unsigned MAX_POLLS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [7:0]    rd_data_i,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          mismatch_o
);
  import fdp_pkg::*;

  fdp_state_e    state_q;
  logic          inflight_q, prog_q, done_q, pass_q, fail_q, mism_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    want_q;

  logic       issue, rvld, same, last_poll, tick;
  logic [7:0] rdat;

  assign issue = (state_q != ST_IDLE) && !inflight_q;
  assign tick  = rvld && (state_q == ST_POLL);

  fdp_read_port u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .rd_req_o   (rd_req_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .data_o     (rdat),
    .vld_o      (rvld)
  );

  fdp_toggle_track u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rvld && (state_q != ST_VERIFY)),
    .bit_i  (rdat[TOG_BIT]),
    .same_o (same)
  );

  fdp_poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wdg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i && (state_q == ST_IDLE)),
    .tick_i (tick),
    .last_o (last_poll)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      inflight_q <= 1'b0;
      prog_q     <= 1'b0;
      addr_q     <= '0;
      want_q     <= '0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      fail_q     <= 1'b0;
      mism_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (issue) inflight_q <= 1'b1;
      else if (rvld) inflight_q <= 1'b0;

      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_FIRST;
          prog_q  <= mode_prog_i;
          addr_q  <= addr_i;
          want_q  <= data_i;
          pass_q  <= 1'b0;
          fail_q  <= 1'b0;
          mism_q  <= 1'b0;
        end
      end else if (rvld) begin
        unique case (state_q)
          ST_FIRST:  state_q <= ST_POLL;
          ST_POLL: begin
            if (same) begin
              if (prog_q) state_q <= ST_VERIFY;
              else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                pass_q  <= 1'b1;
              end
            end else if (rdat[ERR_BIT]) begin
              state_q <= ST_RCHK_A;
            end else if (last_poll) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
            end
          end
          ST_RCHK_A: state_q <= ST_RCHK_B;
          ST_RCHK_B: begin
            if (same && prog_q) state_q <= ST_VERIFY;
            else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              pass_q  <= same;
              fail_q  <= !same;
            end
          end
          ST_VERIFY: begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
            mism_q  <= (rdat != want_q);
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign mismatch_o = mism_q;
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int unsigned MAX_POLLS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rd_req_o,
  input logic rd_valid_i,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input logic mismatch_o
);
  logic        outst_q;
  logic [31:0] nrd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q <= 1'b0;
      nrd_q   <= '0;
    end else begin
      outst_q <= (outst_q | rd_req_o) & !rd_valid_i;
      nrd_q   <= done_o ? 32'd0 : nrd_q + {31'd0, rd_req_o};
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !outst_q);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  p_mism_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> pass_o);
  p_read_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrd_q <= MAX_POLLS + 4);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pass_o, fail_o, mismatch_o}) |-> (done_o || $past(start_i)));
endmodule

bind flash_done_poller fdp_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_valid_i (rd_valid_i),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .mismatch_o (mismatch_o)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;
  localparam int AW = 8;
  localparam int MAXP = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_prog_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic          done_o, pass_o, fail_o, mismatch_o;

  flash_done_poller #(.AW(AW), .MAX_POLLS(MAXP)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int t_g = 1, e_g = 0, lat_g = 0, rd_cnt = 0, addr_err = 0;
  bit err_g = 0, init_g = 0;
  logic [7:0] d_g = '0;
  logic [AW-1:0] exp_addr = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input int k);
    logic [7:0] s;
    if (k < t_g) begin
      s = d_g & 8'h9f;
      s[6] = init_g ^ k[0];
      s[5] = err_g && (k >= e_g);
    end else s = d_g;
    return s;
  endfunction

  // arithmetic model of the polling rules
  task automatic ref_run(input bit prog, input logic [7:0] want,
                         output bit p, output bit f, output bit m, output int n);
    bit prev, done;
    int k, polls;
    logic [7:0] s, a, b;
    p = 0; f = 0; m = 0; done = 0;
    prev = stat(0)[6]; k = 1; polls = 0;
    while (!done) begin
      s = stat(k); k++; polls++;
      if (s[6] == prev) begin p = 1; done = 1; end
      else if (s[5]) begin
        a = stat(k); b = stat(k + 1); k += 2;
        p = (a[6] == b[6]); f = !p; done = 1;
      end else if (polls == MAXP) begin f = 1; done = 1; end
      prev = s[6];
    end
    if (p && prog) begin m = (stat(k) != want); k++; end
    n = k;
  endtask

  // read responder
  initial begin
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      if (rd_req_o) begin
        if (rd_addr_o !== exp_addr) addr_err++;
        repeat (lat_g) @(negedge clk_i);
        rd_valid_i = 1'b1;
        rd_data_i  = stat(rd_cnt);
        rd_cnt++;
      end
    end
  end

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic run(input bit prog, input int kind, input int t, input bit inj);
    bit ep, ef, em;
    int en, cyc;
    logic [7:0] want;
    t_g    = (kind >= 2) ? 1000 : t;
    err_g  = (kind == 1) || (kind == 2);
    e_g    = (kind == 2) ? t : t - 1;
    d_g    = 8'((t * 37) + kind * 11);
    init_g = t[1];
    lat_g  = (t + kind) % 3;
    want   = t[0] ? d_g : d_g ^ 8'h01;
    rd_cnt = 0; addr_err = 0;
    exp_addr = AW'(t * 5 + kind);
    ref_run(prog, want, ep, ef, em, en);
    @(negedge clk_i);
    start_i = 1'b1; mode_prog_i = prog; addr_i = exp_addr; data_i = want;
    @(negedge clk_i);
    start_i = 1'b0; addr_i = ~exp_addr; data_i = ~want; mode_prog_i = !prog;
    cyc = 0;
    while (!done_o && cyc < 1000) begin
      if (inj && cyc == 3) start_i = 1'b1;
      if (inj && cyc == 4) start_i = 1'b0;
      @(negedge clk_i); cyc++;
    end
    start_i = 1'b0;
    check("R9 done seen", done_o, 1);
    check(prog ? "R5/R8 pass (R6 prog)" : "R5/R8 pass (R7 erase)", pass_o, ep);
    check("R3/R5/R8 fail", fail_o, ef);
    check(prog ? "R6 mismatch" : "R7 mismatch", mismatch_o, em);
    check(inj ? "R10 read count" : "R2/R4 read count", rd_cnt, en);
    check("R2 address", addr_err, 0);
    @(negedge clk_i);
    check("R9 done pulse", done_o, 0);
    check("R9 flags hold", {pass_o, fail_o, mismatch_o}, {ep, ef, em});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", {rd_req_o, done_o, pass_o, fail_o, mismatch_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 idle outputs", {rd_req_o, done_o, pass_o, fail_o, mismatch_o}, 0);
    for (int mode = 0; mode < 2; mode++)
      for (int t = 1; t <= 12; t++)
        for (int kind = 0; kind < 4; kind++)
          run(mode[0], kind, t, (kind == 0) && (t == 5));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule